// File: doc/BRIEF.md
# DMA Bus Request Handshake Sequencer

This block sits between four peripheral request lines and a host processor that owns the system bus. When an unmasked channel asks for service, the block chooses one winner by fixed priority and raises a hold request to the host. It then waits for the host's hold acknowledge. Only after that does it acknowledge the winning channel and run byte cycles. Each byte cycle has four phases, and in each byte the block drives a memory strobe paired with the opposite I/O strobe. The pairing depends on the channel's direction.

A channel engine elsewhere keeps address and count. At the end of each byte it tells the sequencer through `more_i` whether another byte follows. A channel flagged as cascade does not run bus cycles. The block forwards the slave controller's request as its own hold request and hands the host's acknowledge back on that channel's acknowledge line.

Top module: `dma_bus_sequencer`

## Requirements
- R1: After reset, `hold_req_o`, `ack_o`, `aen_o`, `astb_o` and all four strobes are low.
- R2: An unmasked request raises `hold_req_o` one clock later. A request whose `mask_i` bit is 1 is ignored, so `hold_req_o` stays low.
- R3: Among unmasked requests raised in the same clock, the lowest channel index wins; channel 0 has the highest priority.
- R4: While `hold_ack_i` has not yet been seen, `ack_o`, `aen_o` and all strobes stay low. `hold_req_o` stays high from the request until the service ends.
- R5: A byte takes four clocks after `hold_ack_i` is seen: address (`aen_o`=1, `astb_o`=1 for exactly that clock), strobe, release (strobes low), decide. `aen_o` and the winner's `ack_o` bit are high during all four.
- R6: With the channel's `dir_i` bit at 1 (memory to I/O), the strobe phase drives `mem_rd_o` and `io_wr_o`. With it at 0 (I/O to memory), the strobe phase drives `io_rd_o` and `mem_wr_o`. No other strobe is active.
- R7: If `more_i` is 1 in the decide phase, the next clock starts another address phase. If it is 0, the next clock drops `hold_req_o`, `ack_o` and `aen_o`.
- R8: If `hold_ack_i` falls during service, the current byte still completes all four phases. The block then releases the bus even when `more_i` is 1.
- R9: For a channel whose `cascade_i` bit is 1, `hold_req_o` follows the slave request and that channel's `ack_o` bit follows `hold_ack_i`. `aen_o`, `astb_o` and the strobes stay low. Dropping the slave request drops `hold_req_o` one clock later.
- R10: At most one `ack_o` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Per-channel service request |
| mask_i | input | 4 | Per-channel mask, 1 disables the channel |
| dir_i | input | 4 | Per-channel direction, 1 = memory to I/O |
| cascade_i | input | 4 | Per-channel cascade flag |
| more_i | input | 1 | Another byte follows, sampled in the decide phase |
| hold_ack_i | input | 1 | Host has released the bus |
| hold_req_o | output | 1 | Bus request to the host |
| ack_o | output | 4 | Per-channel acknowledge |
| aen_o | output | 1 | Address enable, block owns the bus |
| astb_o | output | 1 | Upper address latch strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |

## Verification
The assertions assume that the host raises `hold_ack_i` only while `hold_req_o` is high. They also assume that `dir_i` and `cascade_i` for the serviced channel stay steady until the bus is released. The bench acts as that host: it raises the acknowledge only after seeing the hold request and lowers it after each release. It changes the direction, cascade and mask settings only while the block is idle. All inputs change on the falling edge, so every value sampled at a rising edge is already settled.

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] mask_i,
  input  logic [NCH-1:0] dir_i,
  input  logic [NCH-1:0] cascade_i,
  input  logic           more_i,
  input  logic           hold_ack_i,
  output logic           hold_req_o,
  output logic [NCH-1:0] ack_o,
  output logic           aen_o,
  output logic           astb_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           io_wr_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ADDR, S_STRB, S_RECV, S_DECIDE, S_CASC
  } st_t;

  st_t            st;
  logic [CW-1:0]  ch;
  logic           dir_r;
  logic [NCH-1:0] live;
  logic [CW-1:0]  pick;
  logic           pick_v;
  logic           in_svc;
  logic           strb;

  assign live = req_i & ~mask_i;

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (live[i]) begin
        pick_v = 1'b1;
        pick   = CW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ch    <= '0;
      dir_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE:   if (pick_v) begin
                    st <= S_WAIT;
                    ch <= pick;
                  end
        S_WAIT:   if (hold_ack_i) begin
                    dir_r <= dir_i[ch];
                    st    <= cascade_i[ch] ? S_CASC : S_ADDR;
                  end
        S_ADDR:   st <= S_STRB;
        S_STRB:   st <= S_RECV;
        S_RECV:   st <= S_DECIDE;
        S_DECIDE: st <= (more_i && hold_ack_i) ? S_ADDR : S_IDLE;
        S_CASC:   if (!req_i[ch]) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign in_svc     = (st == S_ADDR) || (st == S_STRB) || (st == S_RECV) || (st == S_DECIDE);
  assign strb       = (st == S_STRB);
  assign hold_req_o = (st != S_IDLE);
  assign aen_o      = in_svc;
  assign astb_o     = (st == S_ADDR);
  assign mem_rd_o   = strb &&  dir_r;
  assign io_wr_o    = strb &&  dir_r;
  assign io_rd_o    = strb && !dir_r;
  assign mem_wr_o   = strb && !dir_r;

  always_comb begin
    ack_o = '0;
    if (in_svc || (st == S_CASC && hold_ack_i)) ack_o[ch] = 1'b1;
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R10
  AST_ACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> hold_req_o); // R4
  AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen_o) |-> $past(hold_ack_i)); // R4
  AST_ASTB_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    astb_o |=> !astb_o); // R5
  AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> (aen_o && (|ack_o))); // R6
  AST_NO_MIXED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o)); // R6
  AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_o || mem_wr_o) |-> $past(astb_o)); // R5
endmodule

// File: tb/dma_bus_sequencer_test.sv
module dma_bus_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req = '0, mask = '0, dir = '0, casc = '0;
  logic more = 1'b0, hlda = 1'b0;
  logic hrq, aen, astb, mr, mw, ir, iw;
  logic [3:0] ack;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dma_bus_sequencer #(.NCH(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .dir_i(dir),
    .cascade_i(casc), .more_i(more), .hold_ack_i(hlda), .hold_req_o(hrq),
    .ack_o(ack), .aen_o(aen), .astb_o(astb), .mem_rd_o(mr), .mem_wr_o(mw),
    .io_rd_o(ir), .io_wr_o(iw)
  );

  // bus vector: hrq aen astb mem_rd mem_wr io_rd io_wr
  localparam logic [6:0] B_IDLE = 7'b0000000;
  localparam logic [6:0] B_HOLD = 7'b1000000;
  localparam logic [6:0] B_ADDR = 7'b1110000;
  localparam logic [6:0] B_M2IO = 7'b1101001;
  localparam logic [6:0] B_IO2M = 7'b1100110;
  localparam logic [6:0] B_OWN  = 7'b1100000;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bus(string tag, logic [3:0] ack_e, logic [6:0] bus_e);
    logic [10:0] act, exp;
    act = {ack, hrq, aen, astb, mr, mw, ir, iw};
    exp = {ack_e, bus_e};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual ack/bus=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_byte(string tag, logic [3:0] a, logic d, logic m);
    expect_bus({tag, " addr phase R5"}, a, B_ADDR);
    more = m;
    step(1);
    expect_bus({tag, " strobe phase R6"}, a, d ? B_M2IO : B_IO2M);
    step(1);
    expect_bus({tag, " release phase R5"}, a, B_OWN);
    step(1);
    expect_bus({tag, " decide phase R5"}, a, B_OWN);
    step(1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(3);
    expect_bus("R1 outputs in reset", 4'b0, B_IDLE);
    rst_n = 1'b1;
    step(1);
    expect_bus("R1 outputs after reset", 4'b0, B_IDLE);
  endtask

  task automatic t_mask;
    mask = 4'b0100;
    req  = 4'b0100;
    step(3);
    expect_bus("R2 masked request ignored", 4'b0, B_IDLE);
    req  = '0;
    mask = '0;
    step(1);
  endtask

  task automatic t_m2io_single;
    dir = 4'b0010;
    req = 4'b0010;
    step(1);
    expect_bus("R2 hold request raised", 4'b0, B_HOLD);
    req = '0;
    step(2);
    expect_bus("R4 no grant before HLDA", 4'b0, B_HOLD);
    hlda = 1'b1;
    step(1);
    do_byte("R6 mem-to-io", 4'b0010, 1'b1, 1'b0);
    expect_bus("R7 release after last byte", 4'b0, B_IDLE);
    hlda = 1'b0;
    dir = '0;
    step(1);
  endtask

  task automatic t_io2m_multi;
    req = 4'b1000;
    step(1);
    expect_bus("R2 hold for channel 3", 4'b0, B_HOLD);
    req = '0;
    hlda = 1'b1;
    step(1);
    do_byte("R7 byte 1", 4'b1000, 1'b0, 1'b1);
    do_byte("R7 byte 2", 4'b1000, 1'b0, 1'b1);
    do_byte("R7 byte 3", 4'b1000, 1'b0, 1'b0);
    expect_bus("R7 release after three bytes", 4'b0, B_IDLE);
    hlda = 1'b0;
    step(1);
  endtask

  task automatic t_priority;
    mask = 4'b0010;
    req  = 4'b1110;
    dir  = 4'b1111;
    step(1);
    req  = '0;
    hlda = 1'b1;
    step(1);
    do_byte("R3 masked ch1 loses to ch2", 4'b0100, 1'b1, 1'b0);
    expect_bus("R3 release", 4'b0, B_IDLE);
    hlda = 1'b0;
    mask = '0;
    req  = 4'b1011;
    step(1);
    req  = '0;
    hlda = 1'b1;
    step(1);
    do_byte("R3 ch0 wins", 4'b0001, 1'b1, 1'b0);
    hlda = 1'b0;
    dir  = '0;
    step(1);
  endtask

  task automatic t_hlda_drop;
    dir = 4'b0001;
    req = 4'b0001;
    step(1);
    req = '0;
    hlda = 1'b1;
    step(1);
    expect_bus("R8 addr before drop", 4'b0001, B_ADDR);
    hlda = 1'b0;
    more = 1'b1;
    step(1);
    expect_bus("R8 strobe still runs", 4'b0001, B_M2IO);
    step(1);
    expect_bus("R8 release phase", 4'b0001, B_OWN);
    step(1);
    expect_bus("R8 decide phase", 4'b0001, B_OWN);
    step(1);
    expect_bus("R8 bus released despite more", 4'b0, B_IDLE);
    more = 1'b0;
    dir = '0;
    step(1);
  endtask

  task automatic t_cascade;
    casc = 4'b0100;
    req  = 4'b0100;
    step(1);
    expect_bus("R9 cascade hold forwarded", 4'b0, B_HOLD);
    step(1);
    expect_bus("R9 no ack before HLDA", 4'b0, B_HOLD);
    hlda = 1'b1;
    step(1);
    expect_bus("R9 ack follows HLDA", 4'b0100, B_HOLD);
    step(3);
    expect_bus("R9 no strobes in cascade", 4'b0100, B_HOLD);
    hlda = 1'b0;
    step(1);
    expect_bus("R9 ack tracks HLDA low", 4'b0, B_HOLD);
    hlda = 1'b1;
    req  = '0;
    step(1);
    expect_bus("R9 release when slave drops", 4'b0, B_IDLE);
    hlda = 1'b0;
    casc = '0;
    step(1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_mask();
    t_m2io_single();
    t_io2m_multi();
    t_priority();
    t_hlda_drop();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule